// File: doc/BRIEF.md
# Power-Fail Supervisor with Time-Save Control

This block supervises the power of a battery-backed real-time clock. It takes three digital indications: a power-fail input, a supply-switchover indication that is high while the clock runs from its battery, and the output of a low-battery comparator. From these it keeps three status bits. The oscillator-fail bit marks that timekeeping was lost. The low-battery bit reports a weak cell. The power-fail flag latches a power-fail event. The block drives a bus lock-out signal and a maskable power-fail interrupt. It also gates a strobe that lets a time-save register bank copy the running time on each clock update.

The oscillator-fail bit comes up set after power-on and stays set until software starts the clock. Software can therefore tell a first power-up from a return after a power failure. Time-save tracking stays on until software clears it, or until the supply actually switches to the battery. A power-fail indication alone does not clear it.

Lock-out is controlled by a four-state machine. `ST_RUN` means unlocked. `ST_LOCK` means a fault is present. `ST_DEB_A` waits for the first debounce tick after power is restored, and `ST_DEB_B` waits for the second. The transitions are as follows:
- any state moves to `ST_LOCK` when a fault is present;
- `ST_LOCK` moves to `ST_DEB_A` when the fault ends;
- `ST_DEB_A` moves to `ST_DEB_B` on a tick;
- `ST_DEB_B` moves to `ST_RUN` on a tick.

A fault is either `pfail_i` high or `on_batt_i` high. The tick comes from a free-running divider of `TICK_DIV` clocks, meant to give 32 Hz. The release therefore falls between one and two tick periods after restoration, which is 31 to 63 ms at 32 Hz.

Register map. The write address and the read address each select one of two 8-bit registers.
- Address 0 is control: bit 0 run, bit 1 battery-mode, bit 2 interrupt enable, bit 3 time-save enable.
- Address 1 is status: bit 0 oscillator-fail, bit 1 low-battery, bit 2 power-fail flag, bit 3 locked.
- Upper bits read 0.

Top module: `pwr_supervisor`

## Requirements
- R1: After reset, control reads 0x00, status reads oscillator-fail=1 and locked=1 with the other bits 0, `lockout_o`=1, `irq_o`=0 and `clk_run_o`=0. Once reset is released with no fault present, lock-out releases by itself after the debounce.
- R2: The oscillator-fail bit (status bit 0) is cleared on the clock edge of a control write that has the run bit (bit 0) set. Any other control write, including one that only changes the battery-mode bit (bit 1), leaves it unchanged. Once cleared, it stays 0 until the next reset.
- R3: The low-battery bit (status bit 1) is registered from the comparator. One clock after the inputs, it equals 1 exactly when the comparator is high, the interrupt enable is 1 and `on_batt_i` is 0.
- R4: A rising edge on `pfail_i` while the enable is 1 and `on_batt_i` is 0 sets the power-fail flag (status bit 2) on that clock edge. The flag stays set until a status write with bit 2 = 1. `irq_o` = flag AND enable AND NOT `on_batt_i`.
- R5: With the interrupt enable at 0, a power-fail rising edge does not set the flag, `irq_o` stays 0 and low-battery detection reads 0. `pfail_i` still drives the lock-out.
- R6: `lockout_o` is 1 from the first clock edge on which `pfail_i` or `on_batt_i` is sampled high, and status bit 3 mirrors it.
- R7: Let fault removal be sampled at edge E0. `lockout_o` falls at edge E0+k with TICK_DIV+1 ≤ k ≤ 2·TICK_DIV. A fault that returns during the debounce keeps lock-out asserted and restarts the debounce.
- R8: `tsave_strobe_o` is high in the same cycle as `clk_update_i` whenever time-save enable (control bit 3) is 1, and is low whenever that enable is 0.
- R9: Time-save enable is cleared on the clock edge after `on_batt_i` rises. It is not cleared by `pfail_i`. A control write with bit 3 = 0 also clears it.
- R10: While `on_batt_i` is 1, `irq_o` is 0, the low-battery bit reads 0 and a latched flag is kept. `irq_o` returns once the supply returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Active-low power-on reset |
| pfail_i | input | 1 | Digital power-fail indication, high while main supply is failing |
| on_batt_i | input | 1 | High while the clock runs from the battery |
| lowbat_cmp_i | input | 1 | Battery comparator, high when below threshold |
| clk_update_i | input | 1 | One-cycle pulse when the clock counters update |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 control, 1 status |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 1 | Read address: 0 control, 1 status |
| rd_data_o | output | DATA_W | Read data of the selected register |
| lockout_o | output | 1 | Bus lock-out |
| irq_o | output | 1 | Power-fail interrupt, active high |
| tsave_strobe_o | output | 1 | Copy strobe to the time-save bank |
| clk_run_o | output | 1 | Clock run (start) bit |

## Verification
The bench measures the debounce latency in clock edges against the window [TICK_DIV+2, 2·TICK_DIV+1] observed after the drive cycle.
- A state machine that unlocks on the first tick fails the lower bound.
- One that ignores a fault returning mid-debounce drops the lock-out early.

The bench writes the battery-mode bit alone and the run bit alone, to catch a design that clears oscillator-fail on any control write. It raises `pfail_i` with time-save enabled, which exposes a design that clears time-save on the fail input instead of on the battery switch. It also takes the supply to battery with a latched flag and a high comparator, which exposes a design that leaks the interrupt or the low-battery bit, or that loses the flag.

// File: rtl/pws_pkg.sv
package pws_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_LOCK  = 2'd1,
        ST_DEB_A = 2'd2,
        ST_DEB_B = 2'd3
    } lock_state_t;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    localparam int CB_RUN  = 0;
    localparam int CB_BATT = 1;
    localparam int CB_PFIE = 2;
    localparam int CB_TSE  = 3;

    localparam int SB_OSCF = 0;
    localparam int SB_LOWB = 1;
    localparam int SB_PFF  = 2;
    localparam int SB_LOCK = 3;

    localparam int CTRL_BITS = 4;

    typedef struct packed {
        logic tse;
        logic pfie;
        logic batt;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/pws_tick_gen.sv
module pws_tick_gen #(
    parameter int DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);

    // R7
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/pws_lock_fsm.sv
module pws_lock_fsm
    import pws_pkg::*;
#(
    parameter int DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pfail_i,
    input  logic on_batt_i,
    input  logic tick_i,
    output logic lockout_o
);
    localparam int DW = $clog2(2 * DIV + 2) + 1;
    localparam logic [DW-1:0] K_MIN = DW'(DIV);
    localparam logic [DW-1:0] K_MAX = DW'(2 * DIV - 1);

    lock_state_t state_q, state_d;
    logic        fault;

    assign fault = pfail_i | on_batt_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCK;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (fault) state_d = ST_LOCK;
            ST_LOCK:  if (!fault) state_d = ST_DEB_A;
            ST_DEB_A: begin
                if (fault)       state_d = ST_LOCK;
                else if (tick_i) state_d = ST_DEB_B;
            end
            ST_DEB_B: begin
                if (fault)       state_d = ST_LOCK;
                else if (tick_i) state_d = ST_RUN;
            end
        endcase
    end

    always_comb begin
        lockout_o = (state_q != ST_RUN);
    end

    logic [DW-1:0] deb_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deb_cnt_q <= '0;
        end else if (state_q == ST_DEB_A || state_q == ST_DEB_B) begin
            deb_cnt_q <= deb_cnt_q + 1'b1;
        end else begin
            deb_cnt_q <= '0;
        end
    end

    // R6
    lock_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> lockout_o);

    // R7
    deb_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEB_B && state_d == ST_RUN) |->
            (deb_cnt_q >= K_MIN && deb_cnt_q <= K_MAX));

endmodule

// File: rtl/pws_regs.sv
module pws_regs
    import pws_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              pfail_i,
    input  logic              on_batt_i,
    input  logic              lowbat_cmp_i,
    input  logic              clk_update_i,
    output ctrl_t             ctrl_o,
    output logic              osc_fail_o,
    output logic              lowbat_o,
    output logic              pf_flag_o,
    output logic              irq_o,
    output logic              tsave_strobe_o
);
    ctrl_t ctrl_q;
    logic  osc_fail_q, lowbat_q, pf_flag_q;
    logic  pfail_q, batt_q;
    logic  pf_rise, batt_rise, pfie_eff, ctrl_wr, stat_wr;

    assign pf_rise   = pfail_i & ~pfail_q;
    assign batt_rise = on_batt_i & ~batt_q;
    assign pfie_eff  = ctrl_q.pfie & ~on_batt_i;
    assign ctrl_wr   = wr_en_i && (wr_addr_i == ADDR_CTRL);
    assign stat_wr   = wr_en_i && (wr_addr_i == ADDR_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pfail_q <= 1'b0;
            batt_q  <= 1'b0;
        end else begin
            pfail_q <= pfail_i;
            batt_q  <= on_batt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= ctrl_t'(wr_data_i[CTRL_BITS-1:0]);
            end
            if (batt_rise) begin
                ctrl_q.tse <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_fail_q <= 1'b1;
        end else if (ctrl_wr && wr_data_i[CB_RUN]) begin
            osc_fail_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lowbat_q <= 1'b0;
        end else begin
            lowbat_q <= pfie_eff & lowbat_cmp_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf_flag_q <= 1'b0;
        end else if (pf_rise && pfie_eff) begin
            pf_flag_q <= 1'b1;
        end else if (stat_wr && wr_data_i[SB_PFF]) begin
            pf_flag_q <= 1'b0;
        end
    end

    assign ctrl_o         = ctrl_q;
    assign osc_fail_o     = osc_fail_q;
    assign lowbat_o       = lowbat_q;
    assign pf_flag_o      = pf_flag_q;
    assign irq_o          = pf_flag_q & pfie_eff;
    assign tsave_strobe_o = ctrl_q.tse & clk_update_i;

    // R2
    osc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_fail_q && !(ctrl_wr && wr_data_i[CB_RUN])) |=> osc_fail_q);

    // R2
    osc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data_i[CB_RUN]) |=> (!osc_fail_q && ctrl_q.run));

    // R3
    lowbat_batt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        on_batt_i |=> !lowbat_o);

    // R4
    pf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pfail_i) && ctrl_q.pfie && !on_batt_i) |=> pf_flag_o);

    // R10
    irq_batt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        on_batt_i |-> !irq_o);

    // R9
    tse_batt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_batt_i) |=> !ctrl_q.tse);

    // R9
    tse_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.tse && !ctrl_wr && !$rose(on_batt_i)) |=> ctrl_q.tse);

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
    import pws_pkg::*;
#(
    parameter int TICK_DIV = 1024,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfail_i,
    input  logic              on_batt_i,
    input  logic              lowbat_cmp_i,
    input  logic              clk_update_i,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              lockout_o,
    output logic              irq_o,
    output logic              tsave_strobe_o,
    output logic              clk_run_o
);
    logic  tick;
    logic  lock;
    ctrl_t ctrl;
    logic  osc_fail, lowbat, pf_flag;

    pws_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    pws_lock_fsm #(.DIV(TICK_DIV)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pfail_i   (pfail_i),
        .on_batt_i (on_batt_i),
        .tick_i    (tick),
        .lockout_o (lock)
    );

    pws_regs #(.DATA_W(DATA_W)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en_i        (wr_en_i),
        .wr_addr_i      (wr_addr_i),
        .wr_data_i      (wr_data_i),
        .pfail_i        (pfail_i),
        .on_batt_i      (on_batt_i),
        .lowbat_cmp_i   (lowbat_cmp_i),
        .clk_update_i   (clk_update_i),
        .ctrl_o         (ctrl),
        .osc_fail_o     (osc_fail),
        .lowbat_o       (lowbat),
        .pf_flag_o      (pf_flag),
        .irq_o          (irq_o),
        .tsave_strobe_o (tsave_strobe_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_CTRL) begin
            rd_data_o[CTRL_BITS-1:0] = ctrl;
        end else begin
            rd_data_o[SB_OSCF] = osc_fail;
            rd_data_o[SB_LOWB] = lowbat;
            rd_data_o[SB_PFF]  = pf_flag;
            rd_data_o[SB_LOCK] = lock;
        end
    end

    assign lockout_o = lock;
    assign clk_run_o = ctrl.run;

    // R8
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tsave_strobe_o |-> (clk_update_i && rd_addr_i == ADDR_STAT) || clk_update_i);

    // R6
    lock_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == ADDR_STAT) |-> (rd_data_o[SB_LOCK] == lockout_o));

endmodule

// File: tb/pwr_supervisor_bench.sv
`timescale 1ns/1ps
module pwr_supervisor_bench;
    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pfail_i = 1'b0, on_batt_i = 1'b0, lowbat_cmp_i = 1'b0, clk_update_i = 1'b0;
    logic       wr_en_i = 1'b0, wr_addr_i = 1'b0, rd_addr_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       lockout_o, irq_o, tsave_strobe_o, clk_run_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pwr_supervisor #(.TICK_DIV(DIV), .DATA_W(8)) u_pwr_supervisor (
        .clk(clk), .rst_n(rst_n), .pfail_i(pfail_i), .on_batt_i(on_batt_i),
        .lowbat_cmp_i(lowbat_cmp_i), .clk_update_i(clk_update_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .lockout_o(lockout_o),
        .irq_o(irq_o), .tsave_strobe_o(tsave_strobe_o), .clk_run_o(clk_run_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        rd_addr_i = a;
        #0.1;
        d = rd_data_o;
    endtask

    // counts posedges after the drive until lock-out is seen low
    task automatic wait_unlock(output int n);
        n = 0;
        while (lockout_o && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic chk_window(input string req, input int n);
        checks++;
        if (n < DIV + 2 || n > 2 * DIV + 1) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, n, DIV + 2, 2 * DIV + 1);
        end
    endtask

    task automatic restore();
        int n;
        @(negedge clk);
        pfail_i = 1'b0; on_batt_i = 1'b0;
        wait_unlock(n);
        chk("R7 restore unlock", lockout_o, 0);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        int n;
        repeat (3) @(negedge clk);
        rd(1'b0, d); chk("R1 ctrl reset", d, 8'h00);
        rd(1'b1, d); chk("R1 status reset", d, 8'h09);
        chk("R1 lockout reset", lockout_o, 1);
        chk("R1 irq reset", irq_o, 0);
        chk("R1 run reset", clk_run_o, 0);
        rst_n = 1'b1;
        wait_unlock(n);
        chk("R1 power-up unlock", lockout_o, 0);
    endtask

    task automatic t_osc();
        logic [7:0] d;
        wr(1'b0, 8'h02);
        rd(1'b1, d); chk("R2 batt-mode write keeps osc-fail", d[0], 1);
        wr(1'b0, 8'h00);
        rd(1'b1, d); chk("R2 zero write keeps osc-fail", d[0], 1);
        wr(1'b0, 8'h03);
        rd(1'b1, d); chk("R2 run clears osc-fail", d[0], 0);
        chk("R2 run out", clk_run_o, 1);
        wr(1'b0, 8'h02);
        rd(1'b1, d); chk("R2 osc-fail stays clear", d[0], 0);
    endtask

    task automatic t_lowbat();
        logic [7:0] d;
        wr(1'b0, 8'h05);
        @(negedge clk); lowbat_cmp_i = 1'b1;
        @(negedge clk);
        rd(1'b1, d); chk("R3 low battery set", d[1], 1);
        lowbat_cmp_i = 1'b0;
        @(negedge clk);
        rd(1'b1, d); chk("R3 low battery follows", d[1], 0);
        wr(1'b0, 8'h01);
        lowbat_cmp_i = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(1'b1, d); chk("R5 masked low battery", d[1], 0);
        wr(1'b0, 8'h05);
        on_batt_i = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(1'b1, d); chk("R10 low battery off on battery", d[1], 0);
        lowbat_cmp_i = 1'b0;
        restore();
    endtask

    task automatic t_irq();
        logic [7:0] d;
        int n;
        wr(1'b0, 8'h05);
        @(negedge clk); pfail_i = 1'b1;
        @(negedge clk);
        rd(1'b1, d); chk("R4 flag set", d[2], 1);
        chk("R4 irq out", irq_o, 1);
        chk("R6 lockout on pfail", lockout_o, 1);
        chk("R6 status lock bit", d[3], 1);
        wr(1'b1, 8'h04);
        rd(1'b1, d); chk("R4 flag cleared", d[2], 0);
        chk("R4 irq cleared", irq_o, 0);
        pfail_i = 1'b0;
        wait_unlock(n);
        chk_window("R7 debounce window", n);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        wr(1'b0, 8'h01);
        @(negedge clk); pfail_i = 1'b1;
        @(negedge clk);
        rd(1'b1, d); chk("R5 masked flag", d[2], 0);
        chk("R5 masked irq", irq_o, 0);
        chk("R5 lockout still driven", lockout_o, 1);
        wr(1'b0, 8'h05);
        rd(1'b1, d); chk("R4 no edge no flag", d[2], 0);
        restore();
    endtask

    task automatic t_retrig();
        int n;
        int high_cnt = 0;
        @(negedge clk); pfail_i = 1'b1;
        @(negedge clk); @(negedge clk);
        pfail_i = 1'b0;
        for (int i = 0; i < DIV / 2; i++) begin
            @(negedge clk);
            if (lockout_o) high_cnt++;
        end
        chk("R7 locked during debounce", high_cnt, DIV / 2);
        pfail_i = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R7 relock", lockout_o, 1);
        pfail_i = 1'b0;
        wait_unlock(n);
        chk_window("R7 restarted window", n);
        // clear flag left by the rising edges above
        wr(1'b1, 8'h04);
    endtask

    task automatic t_tsave();
        logic [7:0] d;
        wr(1'b0, 8'h09);
        @(negedge clk); clk_update_i = 1'b1;
        #0.1; chk("R8 strobe on update", tsave_strobe_o, 1);
        @(negedge clk); clk_update_i = 1'b0;
        #0.1; chk("R8 no strobe without update", tsave_strobe_o, 0);
        pfail_i = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(1'b0, d); chk("R9 pfail keeps time-save", d[3], 1);
        restore();
        @(negedge clk); on_batt_i = 1'b1;
        @(negedge clk);
        rd(1'b0, d); chk("R9 battery clears time-save", d[3], 0);
        restore();
        wr(1'b0, 8'h09);
        wr(1'b0, 8'h01);
        rd(1'b0, d); chk("R9 software clear", d[3], 0);
        @(negedge clk); clk_update_i = 1'b1;
        #0.1; chk("R8 strobe gated off", tsave_strobe_o, 0);
        @(negedge clk); clk_update_i = 1'b0;
    endtask

    task automatic t_batt();
        logic [7:0] d;
        wr(1'b0, 8'h05);
        @(negedge clk); pfail_i = 1'b1;
        @(negedge clk);
        chk("R4 irq before battery", irq_o, 1);
        on_batt_i = 1'b1;
        #0.1; chk("R10 irq off on battery", irq_o, 0);
        @(negedge clk);
        rd(1'b1, d); chk("R10 flag kept on battery", d[2], 1);
        on_batt_i = 1'b0;
        #0.1; chk("R10 irq back", irq_o, 1);
        wr(1'b1, 8'h04);
        pfail_i = 1'b0;
        @(negedge clk); on_batt_i = 1'b1;
        @(negedge clk); pfail_i = 1'b1;
        @(negedge clk);
        rd(1'b1, d); chk("R10 no flag on battery", d[2], 0);
        restore();
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_osc();
        t_lowbat();
        t_irq();
        t_mask();
        t_retrig();
        t_tsave();
        t_batt();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule